// File: doc/BRIEF.md
# Dime and Quarter Vending Controller with Change

This block is a small synchronous state machine that sits behind a coin
acceptor and decides when an item costing 30 cents is released. The
acceptor presents a 2-bit coin code once per clock, meaning no coin, a
dime or a quarter. The machine remembers what has been paid so far in one
of four states: idle, one dime in, one quarter in, or two dimes in.

When a coin completes a purchase, the outputs respond on that same clock,
combinationally from the current state and the incoming coin. The block
raises the release strobe and, if money is owed back, exactly one of two
change strobes: 5 cents or 20 cents. The next edge then takes the machine
back to idle.

An active-low asynchronous reset and a synchronous clear both force idle.
A build parameter selects binary or one-hot state encoding. Both give the
same behaviour at the ports.

Top module: `vend_change_fsm`

## Requirements
- R1: Coin code 2'b01 is a dime and 2'b10 is a quarter. Codes 2'b00 and 2'b11 both mean no coin.
- R2: A cycle with no coin keeps all three outputs low and leaves the stored payment unchanged.
- R3: Three dimes in a row release the item on the third dime, with both change outputs low.
- R4: A dime followed by a quarter releases the item and raises the 5-cent change output.
- R5: A quarter followed by a dime releases the item and raises the 5-cent change output.
- R6: Two quarters release the item and raise the 20-cent change output.
- R7: The release and change outputs are high only during the clock cycle in which the completing coin is presented.
- R8: After a release the machine is idle, so one further quarter alone releases nothing.
- R9: A change output is never high without the release output, and the two change outputs are never high together.
- R10: Driving rst_ni low at any time returns the machine to idle, discarding any partial payment.
- R11: While clear_i is high all outputs stay low and any coin is ignored. The next edge leaves the machine idle.
- R12: A quarter presented after two dimes completes the purchase: release high, both change outputs low.
- R13: A coin that does not complete a purchase raises no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous return to idle, active high |
| coin_i | input | 2 | Coin code for this cycle (01 dime, 10 quarter, 00 or 11 none) |
| vend_o | output | 1 | Release the item |
| chg20_o | output | 1 | Return 20 cents |
| chg5_o | output | 1 | Return 5 cents |

## Verification
The bench builds two copies side by side, one with ONE_HOT set to 1 and one with the default binary encoding. Every cycle is compared against the same expected outputs, so a fault in either state-register variant is caught by the same sequences. The stimulus covers all four permitted purchases, idle cycles and the 2'b11 code placed between coins, and the over-paying quarter after two dimes. It also places a clear and an asynchronous reset in the middle of a purchase, each followed by coins whose outcome differs depending on whether the partial payment was really discarded.

// File: rtl/vend_pkg.sv
`timescale 1ns/1ps
package vend_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DIME  = 2'd1,
    ST_QTR   = 2'd2,
    ST_DIME2 = 2'd3
  } vend_st_e;

  localparam int unsigned NUM_ST = 4;
endpackage

// File: rtl/vend_coin_decode.sv
`timescale 1ns/1ps
module vend_coin_decode #(
  parameter int unsigned COIN_W = 2,
  parameter logic [COIN_W-1:0] DIME_CODE = 'd1,
  parameter logic [COIN_W-1:0] QTR_CODE  = 'd2
) (
  input  logic [COIN_W-1:0] coin_i,
  output logic              dime_o,
  output logic              qtr_o
);
  // any other code, including all-ones, reads as no coin
  assign dime_o = (coin_i == DIME_CODE);
  assign qtr_o  = (coin_i == QTR_CODE);
endmodule

// File: rtl/vend_state_reg.sv
`timescale 1ns/1ps
module vend_state_reg
  import vend_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  vend_st_e nxt_i,
  output vend_st_e st_o
);
  generate
    if (ONE_HOT) begin : g_onehot
      logic [NUM_ST-1:0] oh_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) oh_q <= NUM_ST'(1);
        else         oh_q <= NUM_ST'(1) << nxt_i;
      end

      always_comb begin
        st_o = ST_IDLE;
        for (int i = 0; i < NUM_ST; i++) begin
          if (oh_q[i]) st_o = vend_st_e'(2'(i));
        end
      end

      assert_state_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(oh_q) == 1);
    end else begin : g_binary
      vend_st_e st_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_IDLE;
        else         st_q <= nxt_i;
      end

      assign st_o = st_q;
    end
  endgenerate
endmodule

// File: rtl/vend_next_logic.sv
`timescale 1ns/1ps
module vend_next_logic
  import vend_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  vend_st_e st_i,
  input  logic     dime_i,
  input  logic     qtr_i,
  input  logic     clear_i,
  output vend_st_e nxt_o,
  output logic     vend_o,
  output logic     chg20_o,
  output logic     chg5_o
);
  always_comb begin
    nxt_o   = st_i;
    vend_o  = 1'b0;
    chg20_o = 1'b0;
    chg5_o  = 1'b0;
    if (clear_i) begin
      nxt_o = ST_IDLE;
    end else if (dime_i || qtr_i) begin
      case (st_i)
        ST_IDLE: nxt_o = dime_i ? ST_DIME : ST_QTR;
        ST_DIME: begin
          if (dime_i) begin
            nxt_o = ST_DIME2;
          end else begin
            nxt_o  = ST_IDLE;
            vend_o = 1'b1;
            chg5_o = 1'b1;
          end
        end
        ST_QTR: begin
          nxt_o   = ST_IDLE;
          vend_o  = 1'b1;
          chg20_o = qtr_i;
          chg5_o  = dime_i;
        end
        ST_DIME2: begin
          // 30 or 45 cents paid: release, no change owed by policy
          nxt_o  = ST_IDLE;
          vend_o = 1'b1;
        end
        default: nxt_o = ST_IDLE;
      endcase
    end
  end

  assert_change_with_vend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg20_o || chg5_o) |-> vend_o);
  assert_single_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({chg20_o, chg5_o}));
  assert_quiet_no_coin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dime_i || qtr_i) |-> !vend_o);
  assert_clear_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> !(vend_o || chg20_o || chg5_o));
endmodule

// File: rtl/vend_change_fsm.sv
`timescale 1ns/1ps
module vend_change_fsm
  import vend_pkg::*;
#(
  parameter int unsigned COIN_W  = 2,
  parameter bit          ONE_HOT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [COIN_W-1:0] coin_i,
  output logic              vend_o,
  output logic              chg20_o,
  output logic              chg5_o
);
  localparam logic [COIN_W-1:0] DIME_CODE = COIN_W'(1);
  localparam logic [COIN_W-1:0] QTR_CODE  = COIN_W'(2);

  logic     dime, qtr;
  vend_st_e st, nxt;

  vend_coin_decode #(
    .COIN_W   (COIN_W),
    .DIME_CODE(DIME_CODE),
    .QTR_CODE (QTR_CODE)
  ) u_decode (
    .coin_i(coin_i),
    .dime_o(dime),
    .qtr_o (qtr)
  );

  vend_state_reg #(
    .ONE_HOT(ONE_HOT)
  ) u_state (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nxt_i (nxt),
    .st_o  (st)
  );

  vend_next_logic u_next (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .st_i   (st),
    .dime_i (dime),
    .qtr_i  (qtr),
    .clear_i(clear_i),
    .nxt_o  (nxt),
    .vend_o (vend_o),
    .chg20_o(chg20_o),
    .chg5_o (chg5_o)
  );

  assert_idle_after_vend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vend_o |=> (st == ST_IDLE));
  assert_clear_to_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (st == ST_IDLE));
  assert_hold_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !dime && !qtr) |=> $stable(st));
  assert_all_ones_no_vend_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coin_i == '1) |-> !vend_o);
endmodule

// File: tb/tb_vend_change_fsm.sv
`timescale 1ns/1ps
module tb_vend_change_fsm;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr = 1'b0;
  logic [1:0] coin = 2'b00;
  logic       vend_a, c20_a, c5_a;
  logic       vend_b, c20_b, c5_b;

  int checks = 0;
  int fails  = 0;
  int ms     = 0;   // model: 0 idle, 1 one dime, 2 one quarter, 3 two dimes
  bit done   = 1'b0;

  typedef struct {
    logic [2:0] exp;  // {vend, chg20, chg5}
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  vend_change_fsm #(.ONE_HOT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clr), .coin_i(coin),
    .vend_o(vend_a), .chg20_o(c20_a), .chg5_o(c5_a)
  );

  vend_change_fsm #(.ONE_HOT(1'b0)) dut_bin (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clr), .coin_i(coin),
    .vend_o(vend_b), .chg20_o(c20_b), .chg5_o(c5_b)
  );

  task automatic drive(input logic [1:0] c, input logic cl, input string tag);
    item_t it;
    logic [2:0] e = 3'b000;
    @(negedge clk);
    coin = c;
    clr  = cl;
    if (cl) begin
      ms = 0;
    end else if (c == 2'b01 || c == 2'b10) begin
      case (ms)
        0: ms = (c == 2'b01) ? 1 : 2;
        1: if (c == 2'b01) ms = 3; else begin e = 3'b101; ms = 0; end
        2: begin e = (c == 2'b10) ? 3'b110 : 3'b101; ms = 0; end
        default: begin e = 3'b100; ms = 0; end
      endcase
    end
    it.exp = e;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    coin   = 2'b00;
    clr    = 1'b0;
    #0.5 rst_ni = 1'b0;
    ms     = 0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if ({vend_a, c20_a, c5_a} !== it.exp) begin
        fails++;
        $display("FAIL %s one-hot: got %b expected %b", it.tag, {vend_a, c20_a, c5_a}, it.exp);
      end
      checks++;
      if ({vend_b, c20_b, c5_b} !== it.exp) begin
        fails++;
        $display("FAIL %s binary: got %b expected %b", it.tag, {vend_b, c20_b, c5_b}, it.exp);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    drive(2'b00, 1'b0, "R10");
    drive(2'b00, 1'b0, "R10");
    // R3 with idle gaps
    drive(2'b01, 1'b0, "R13");
    drive(2'b00, 1'b0, "R2");
    drive(2'b01, 1'b0, "R13");
    drive(2'b00, 1'b0, "R2");
    drive(2'b01, 1'b0, "R3");
    drive(2'b00, 1'b0, "R7");
    // R4
    drive(2'b01, 1'b0, "R13");
    drive(2'b10, 1'b0, "R4");
    drive(2'b00, 1'b0, "R7");
    // R5
    drive(2'b10, 1'b0, "R13");
    drive(2'b00, 1'b0, "R2");
    drive(2'b00, 1'b0, "R2");
    drive(2'b01, 1'b0, "R5");
    // R6 then R8
    drive(2'b10, 1'b0, "R13");
    drive(2'b10, 1'b0, "R6");
    drive(2'b10, 1'b0, "R8");
    drive(2'b01, 1'b0, "R8");
    // R1: code 11 between dimes
    drive(2'b01, 1'b0, "R13");
    drive(2'b11, 1'b0, "R1");
    drive(2'b11, 1'b0, "R1");
    drive(2'b01, 1'b0, "R1");
    drive(2'b01, 1'b0, "R1");
    // R12
    drive(2'b01, 1'b0, "R13");
    drive(2'b01, 1'b0, "R13");
    drive(2'b10, 1'b0, "R12");
    // R11: clear discards one dime, then coin under clear ignored
    drive(2'b01, 1'b0, "R13");
    drive(2'b00, 1'b1, "R11");
    drive(2'b10, 1'b0, "R11");
    drive(2'b10, 1'b0, "R11");
    drive(2'b01, 1'b0, "R13");
    drive(2'b01, 1'b1, "R11");
    drive(2'b01, 1'b0, "R11");
    drive(2'b01, 1'b0, "R11");
    drive(2'b01, 1'b0, "R11");
    // R10: reset discards one dime
    drive(2'b01, 1'b0, "R13");
    pulse_reset();
    drive(2'b01, 1'b0, "R10");
    drive(2'b10, 1'b0, "R10");
    drive(2'b00, 1'b0, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule